// File: doc/BRIEF.md
# Five-Level Phase-Opposition Carrier Modulator

This block drives one phase of a five-level packed U-cell that sits in series with a slow main bridge as a harmonic-compensation stage. Its input is a signed reference word that already has the bridge's fundamental removed, so the cell only synthesises harmonic content. One triangular up/down counter produces four level-shifted carriers stacked across the reference range. Each carrier is inverted relative to its neighbours. Comparing the reference against all four carriers yields an output level between -2 and +2.

The chosen level is then turned into on/off states for the three complementary switch pairs. These are the outer-left pair, the middle pair and the outer-right pair. The two extreme levels have a single valid state. Levels -1, 0 and +1 can each be made in more than one way, and the mapper uses that freedom to hold the high-stress middle pair still for as long as the reference keeps its sign. Each pair then passes through a dead-time stage that holds both of its gates low for a programmable number of cycles around every change.

The carrier half-period `CMAX` sets the carrier frequency. At a 125 MHz clock the default gives about 3.2 kHz. The dead time is a run-time input.

Top module: `pcu_apod_mod`

## Requirements
- R1: The carrier counter resets to 0 counting up. It steps by one every clock, turns down on reaching `CMAX`, turns up on reaching 0, and so repeats with a period of 2*`CMAX` clocks.
- R2: Carrier k (k = 0..3) lies in the band from (k-2)*`CMAX` to (k-1)*`CMAX`. It equals the band floor plus the counter for even k, and the band floor plus (`CMAX` minus the counter) for odd k. The registered level on `level_o` is the number of carriers strictly below the signed reference, minus 2, and appears one clock after the sampled counter and reference.
- R3: A reference greater than 2*`CMAX` always gives level +2. A reference at or below -2*`CMAX` always gives level -2.
- R4: State bits L (outer-left), M (middle) and N (outer-right) are 1 when the pair's upper gate is to be on. The level equals L+N-2M. Level +2 is only L=1, M=0, N=1, and level -2 is only L=0, M=1, N=0.
- R5: For level 0, M keeps its present value and L=N=M.
- R6: Levels +1 and +2 force M=0, and levels -1 and -2 force M=1. M changes only when the new level forces it.
- R7: For level +1 or -1, exactly one outer pair is on. The mapper picks the candidate with fewer bit changes from the present state. On a tie it alternates, starting with L=1, N=0 after reset.
- R8: The switch state is registered one clock after the level. A pair's gates react one clock after its state bit changes.
- R9: When a pair's state bit changes, both of its gates are low for D+1 clocks, where D is `dead_cycles_i` sampled at the change. The pair then drives upper = state and lower = not state.
- R10: The upper and lower gates of a pair are never high together.
- R11: In reset, all gates are low and the level is 0. On the first clock after reset, all lower gates turn on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | REF_W | Signed harmonic reference, one carrier band = `CMAX` counts |
| dead_cycles_i | input | DT_W | Dead-time length D in clocks |
| level_o | output | 3 | Signed chosen level, -2..+2 |
| gate_hi_o | output | 3 | Upper gates: bit 2 outer-left, bit 1 middle, bit 0 outer-right |
| gate_lo_o | output | 3 | Lower gates, same bit order |

## Verification
The hardest conditions to reach from the ports are the tie in the outer-pair choice and the middle pair's hold through level 0. Both need the level to move between particular neighbours while the middle pair already holds a given value. The bench first parks the cell at a saturated level with a reference beyond the carrier range. It then sets a constant reference inside one band, so that the moving carriers toggle the level between a known pair of values for several periods. It counts edges on the outer and middle gates during that window. A seeded random phase then sweeps references and dead times against a cycle-level reference model.

// File: rtl/pcu_apod_pkg.sv
package pcu_apod_pkg;

  // switch state of the cell: bit 2 outer-left, bit 1 middle, bit 0 outer-right
  typedef struct packed {
    logic l;
    logic m;
    logic n;
  } cell_state_t;

  // level code: 0..4 stands for -2..+2
  typedef logic [2:0] lvl_code_t;

  localparam lvl_code_t CODE_NEG2 = 3'd0;
  localparam lvl_code_t CODE_NEG1 = 3'd1;
  localparam lvl_code_t CODE_ZERO = 3'd2;
  localparam lvl_code_t CODE_POS1 = 3'd3;
  localparam lvl_code_t CODE_POS2 = 3'd4;

  function automatic int state_dist(cell_state_t a, cell_state_t b);
    return $countones(a ^ b);
  endfunction

endpackage

// File: rtl/apod_carrier_gen.sv
module apod_carrier_gen #(
  parameter int CMAX  = 19531,
  parameter int CNT_W = 15,
  parameter int CMP_W = 19
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [3:0][CMP_W-1:0]      car_o
);

  localparam logic [CNT_W-1:0] TOP      = CNT_W'(CMAX);
  localparam logic [CNT_W-1:0] TOP_M1   = CNT_W'(CMAX - 1);
  localparam logic [CMP_W-1:0] TOP_EXT  = CMP_W'(CMAX);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == TOP_M1) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  logic [CMP_W-1:0] cnt_ext;
  assign cnt_ext = CMP_W'(cnt_q);

  // four stacked carriers, neighbours in phase opposition
  for (genvar k = 0; k < 4; k++) begin : g_band
    localparam logic [CMP_W-1:0] FLOOR = CMP_W'((k - 2) * CMAX);
    if (k % 2 == 0) begin : g_rise
      assign car_o[k] = FLOOR + cnt_ext;
    end else begin : g_fall
      assign car_o[k] = FLOOR + (TOP_EXT - cnt_ext);
    end
  end

  logic unused_top;
  assign unused_top = ^TOP;

endmodule

// File: rtl/apod_level_sel.sv
module apod_level_sel
  import pcu_apod_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CMP_W = 19
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [REF_W-1:0]       ref_i,
  input  logic [3:0][CMP_W-1:0]  car_i,
  output lvl_code_t              code_o
);

  localparam int PAD = CMP_W - REF_W;

  logic [CMP_W-1:0] ref_ext;
  logic [3:0]       above;
  lvl_code_t        code_d;

  assign ref_ext = {{PAD{ref_i[REF_W-1]}}, ref_i};

  for (genvar k = 0; k < 4; k++) begin : g_cmp
    assign above[k] = $signed(ref_ext) > $signed(car_i[k]);
  end

  always_comb begin
    code_d = '0;
    for (int k = 0; k < 4; k++) begin
      code_d = code_d + {2'b00, above[k]};
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) code_o <= CODE_ZERO;
    else       code_o <= code_d;
  end

endmodule

// File: rtl/pcu_state_mapper.sv
module pcu_state_mapper
  import pcu_apod_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  lvl_code_t   code_i,
  output cell_state_t state_o
);

  cell_state_t nxt;
  cell_state_t cand_a;
  cell_state_t cand_b;
  logic        tie_q;
  logic        tie_d;
  logic        m_sel;
  int          dist_a;
  int          dist_b;

  always_comb begin
    m_sel  = (code_i == CODE_NEG1);
    cand_a = '{l: 1'b1, m: m_sel, n: 1'b0};
    cand_b = '{l: 1'b0, m: m_sel, n: 1'b1};
    dist_a = state_dist(cand_a, state_o);
    dist_b = state_dist(cand_b, state_o);
    nxt    = state_o;
    tie_d  = tie_q;
    unique case (code_i)
      CODE_POS2: nxt = '{l: 1'b1, m: 1'b0, n: 1'b1};
      CODE_NEG2: nxt = '{l: 1'b0, m: 1'b1, n: 1'b0};
      CODE_ZERO: nxt = '{l: state_o.m, m: state_o.m, n: state_o.m};
      CODE_POS1, CODE_NEG1: begin
        if (dist_a < dist_b)      nxt = cand_a;
        else if (dist_b < dist_a) nxt = cand_b;
        else begin
          nxt   = tie_q ? cand_b : cand_a;
          tie_d = ~tie_q;
        end
      end
      default: nxt = state_o;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_o <= '0;
      tie_q   <= 1'b0;
    end else begin
      state_o <= nxt;
      tie_q   <= tie_d;
    end
  end

endmodule

// File: rtl/pcu_dead_time.sv
module pcu_dead_time #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);

  logic            cur_q;
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_q  <= 1'b0;
      wait_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (cmd_i != cur_q) begin
      cur_q  <= cmd_i;
      wait_q <= dead_i;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else begin
      hi_o   <= cur_q;
      lo_o   <= ~cur_q;
    end
  end

endmodule

// File: rtl/pcu_apod_mod.sv
module pcu_apod_mod
  import pcu_apod_pkg::*;
#(
  parameter int CMAX  = 19531,
  parameter int REF_W = 16,
  parameter int DT_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]         dead_cycles_i,
  output logic signed [2:0]       level_o,
  output logic [2:0]              gate_hi_o,
  output logic [2:0]              gate_lo_o
);

  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int CW    = CNT_W + 3;
  localparam int CMP_W = ((REF_W > CW) ? REF_W : CW) + 1;

  logic [CNT_W-1:0]          cnt_w;
  logic [3:0][CMP_W-1:0]     car_w;
  lvl_code_t                 code_w;
  cell_state_t               state_w;
  logic [2:0]                state_vec;

  apod_carrier_gen #(.CMAX(CMAX), .CNT_W(CNT_W), .CMP_W(CMP_W)) carrier_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_o (cnt_w),
    .car_o (car_w)
  );

  apod_level_sel #(.REF_W(REF_W), .CMP_W(CMP_W)) level_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ref_i  (ref_i),
    .car_i  (car_w),
    .code_o (code_w)
  );

  pcu_state_mapper mapper_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .code_i  (code_w),
    .state_o (state_w)
  );

  assign state_vec = state_w;
  assign level_o   = $signed(code_w - 3'd2);

  for (genvar p = 0; p < 3; p++) begin : g_pair
    pcu_dead_time #(.DT_W(DT_W)) dt_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .cmd_i  (state_vec[p]),
      .dead_i (dead_cycles_i),
      .hi_o   (gate_hi_o[p]),
      .lo_o   (gate_lo_o[p])
    );
  end

endmodule

// File: rtl/pcu_apod_mod_chk.sv
module pcu_apod_mod_chk #(
  parameter int CMAX  = 19531,
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [2:0]       code_i,
  input logic [2:0]       state_i,
  input logic [2:0]       gate_hi_i,
  input logic [2:0]       gate_lo_i
);

  logic [3:0] st_lvl;
  assign st_lvl = 4'(state_i[2]) + 4'(state_i[0]) - 4'({state_i[1], 1'b0});

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_i <= CNT_W'(CMAX));

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == $past(cnt_i) - 1'b1));

  // R2
  code_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    code_i <= 3'd4);

  // R4 R8
  state_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> st_lvl == 4'($past(code_i)) - 4'd2);

  // R5
  mid_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_i == 3'd2) |=> state_i[1] == $past(state_i[1]));

  // R6
  mid_forced_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (state_i[1] == $past(state_i[1])) || ($past(code_i) != 3'd2));

  // R10
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (gate_hi_i & gate_lo_i) == 3'b000);

  // R9
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((gate_hi_i & ~$past(gate_hi_i) & $past(gate_lo_i)) |
              (gate_lo_i & ~$past(gate_lo_i) & $past(gate_hi_i))) == 3'b000);

endmodule

bind pcu_apod_mod pcu_apod_mod_chk #(.CMAX(CMAX), .CNT_W(CNT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cnt_i     (cnt_w),
  .code_i    (code_w),
  .state_i   (state_vec),
  .gate_hi_i (gate_hi_o),
  .gate_lo_i (gate_lo_o)
);

// File: tb/pcu_apod_mod_tb_top.sv
module pcu_apod_mod_tb_top;

  localparam int CMAX  = 20;
  localparam int REF_W = 8;
  localparam int DT_W  = 3;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [REF_W-1:0] ref_r = '0;
  logic [DT_W-1:0]         dead = 3'd1;
  logic signed [2:0]       level_o;
  logic [2:0]              gate_hi_o;
  logic [2:0]              gate_lo_o;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcu_apod_mod #(.CMAX(CMAX), .REF_W(REF_W), .DT_W(DT_W)) dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .ref_i         (ref_r),
    .dead_cycles_i (dead),
    .level_o       (level_o),
    .gate_hi_o     (gate_hi_o),
    .gate_lo_o     (gate_lo_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model built from the requirements ----------------
  int         m_cnt;
  bit         m_up;
  int         m_code;
  logic [2:0] m_state;
  bit         m_flag;
  logic [2:0] m_cur;
  int         m_wait [3];
  logic [2:0] m_hi, m_lo;

  function automatic logic [3:0] bmap(int code, logic [2:0] cur, bit flag);
    logic [2:0] a, b, r;
    int da, db;
    bit f;
    f = flag;
    r = cur;
    if (code == 4) r = 3'b101;
    else if (code == 0) r = 3'b010;
    else if (code == 2) r = {cur[1], cur[1], cur[1]};
    else begin
      a = {1'b1, code == 1, 1'b0};
      b = {1'b0, code == 1, 1'b1};
      da = $countones(a ^ cur);
      db = $countones(b ^ cur);
      if (da < db) r = a;
      else if (db < da) r = b;
      else begin
        r = flag ? b : a;
        f = ~flag;
      end
    end
    return {f, r};
  endfunction

  always @(posedge clk) begin : model
    int code_n;
    int car;
    logic [3:0] mp;
    if (rst) begin
      m_cnt <= 0; m_up <= 1; m_code <= 2; m_state <= 3'b000; m_flag <= 0;
      m_cur <= 3'b000; m_hi <= 3'b000; m_lo <= 3'b000;
      for (int i = 0; i < 3; i++) m_wait[i] <= 0;
    end else begin
      code_n = 0;
      for (int k = 0; k < 4; k++) begin
        car = (k - 2) * CMAX + ((k % 2 == 0) ? m_cnt : CMAX - m_cnt);
        if (int'(ref_r) > car) code_n++;
      end
      m_code <= code_n;
      if (m_up) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt + 1 == CMAX) m_up <= 0;
      end else begin
        m_cnt <= m_cnt - 1;
        if (m_cnt - 1 == 0) m_up <= 1;
      end
      mp = bmap(m_code, m_state, m_flag);
      m_state <= mp[2:0];
      m_flag  <= mp[3];
      for (int i = 0; i < 3; i++) begin
        if (m_state[i] != m_cur[i]) begin
          m_cur[i] <= m_state[i]; m_wait[i] <= int'(dead);
          m_hi[i] <= 0; m_lo[i] <= 0;
        end else if (m_wait[i] != 0) begin
          m_wait[i] <= m_wait[i] - 1;
          m_hi[i] <= 0; m_lo[i] <= 0;
        end else begin
          m_hi[i] <= m_cur[i]; m_lo[i] <= ~m_cur[i];
        end
      end
    end
  end

  // ---------------- continuous comparison and edge counting ----------------
  int         cyc = 0;
  int         mid_chg = 0, drop_l = 0, drop_n = 0;
  logic [2:0] prev_hi = 3'b000;

  always @(negedge clk) begin
    cyc++;
    if (live && !rst) begin
      chk(int'(level_o) == m_code - 2, "R2 level", int'(level_o), m_code - 2);
      chk(gate_hi_o == m_hi && gate_lo_o == m_lo, "R9 gates",
          int'({gate_hi_o, gate_lo_o}), int'({m_hi, m_lo}));
      chk((gate_hi_o & gate_lo_o) == 3'b000, "R10 shoot-through",
          int'(gate_hi_o & gate_lo_o), 0);
    end
    if (gate_hi_o[1] != prev_hi[1]) mid_chg++;
    if (prev_hi[2] && !gate_hi_o[2]) drop_l++;
    if (prev_hi[0] && !gate_hi_o[0]) drop_n++;
    prev_hi = gate_hi_o;
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int t0, t1, a, b, lows;
    bit all_ok;
    void'($urandom(32'd7331));

    // R11 reset state
    wait_neg(3);
    chk(level_o == 3'sd0, "R11 reset level", int'(level_o), 0);
    chk(gate_hi_o == 0 && gate_lo_o == 0, "R11 reset gates",
        int'({gate_hi_o, gate_lo_o}), 0);
    rst = 1'b0;
    wait_neg(1);
    chk(gate_lo_o == 3'b111 && gate_hi_o == 3'b000, "R11 lower gates on",
        int'({gate_hi_o, gate_lo_o}), 7);
    live = 1'b1;

    // R1: with ref 0 the level dips to -1 only when the counter is 0
    ref_r = 0;
    t0 = -1; t1 = -1;
    for (int i = 0; i < 200 && t1 < 0; i++) begin
      wait_neg(1);
      if (level_o == -3'sd1) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
    end
    chk(t1 - t0 == 2 * CMAX, "R1 carrier period", t1 - t0, 2 * CMAX);

    // R3 saturation
    ref_r = 8'sd41;
    wait_neg(3);
    all_ok = 1;
    for (int i = 0; i < 2 * CMAX; i++) begin
      wait_neg(1);
      if (level_o != 3'sd2) all_ok = 0;
    end
    chk(all_ok, "R3 above range gives +2", int'(level_o), 2);
    ref_r = -8'sd40;
    wait_neg(3);
    all_ok = 1;
    for (int i = 0; i < 2 * CMAX; i++) begin
      wait_neg(1);
      if (level_o != -3'sd2) all_ok = 0;
    end
    chk(all_ok, "R3 at -2*CMAX gives -2", int'(level_o), -2);

    // R4 unique state of -2
    wait_neg(10);
    chk(gate_hi_o == 3'b010 && gate_lo_o == 3'b101, "R4 state of -2",
        int'(gate_hi_o), 2);

    // R8 / R9 step -2 -> +2 with dead time 3
    dead = 3'd3;
    wait_neg(2);
    ref_r = 8'sd41;
    wait_neg(1);
    chk(level_o == 3'sd2, "R8 level after step", int'(level_o), 2);
    wait_neg(1);
    chk(gate_hi_o[1] == 1'b1, "R8 middle gate one clock after state", int'(gate_hi_o[1]), 1);
    wait_neg(1);
    lows = 0;
    while (lows < 20 && !gate_hi_o[1] && !gate_lo_o[1]) begin
      lows++;
      wait_neg(1);
    end
    chk(lows == 4, "R9 dead interval D+1", lows, 4);
    chk(gate_lo_o[1] == 1'b1, "R9 middle lower after dead time", int'(gate_lo_o[1]), 1);
    dead = 3'd1;
    wait_neg(10);
    chk(gate_hi_o == 3'b101 && gate_lo_o == 3'b010, "R4 state of +2",
        int'(gate_hi_o), 5);

    // R7 toggling +2/+1: outer pairs take turns
    a = drop_l; b = drop_n; t0 = mid_chg;
    ref_r = 8'sd30;
    wait_neg(8 * 2 * CMAX);
    ref_r = 8'sd41;
    wait_neg(10);
    a = drop_l - a; b = drop_n - b;
    chk(a > 0 && b > 0 && (a - b <= 1) && (b - a <= 1), "R7 alternation L/N drops", a, b);
    chk(mid_chg == t0, "R6 middle still for positive levels", mid_chg - t0, 0);

    // R5 levels 0/+1 with M=0 keep middle still
    t0 = mid_chg;
    ref_r = 8'sd10;
    wait_neg(6 * 2 * CMAX);
    ref_r = 8'sd41;
    wait_neg(10);
    chk(mid_chg == t0, "R5 middle held through 0 (M=0)", mid_chg - t0, 0);

    // R5 levels -1/0 with M=1 keep middle still
    ref_r = -8'sd41;
    wait_neg(12);
    t0 = mid_chg;
    ref_r = -8'sd10;
    wait_neg(6 * 2 * CMAX);
    ref_r = -8'sd41;
    wait_neg(10);
    chk(mid_chg == t0, "R5 middle held through 0 (M=1)", mid_chg - t0, 0);

    // R6 from -2 into 0/+1: exactly one middle change
    t0 = mid_chg;
    ref_r = 8'sd10;
    wait_neg(6 * 2 * CMAX);
    ref_r = 8'sd41;
    wait_neg(10);
    chk(mid_chg - t0 == 1, "R6 single forced middle change", mid_chg - t0, 1);

    // random phase against the model (R2, R9, R10 checked each cycle)
    for (int it = 0; it < 1500; it++) begin
      ref_r = REF_W'(int'($urandom_range(90)) - 45);
      if ($urandom_range(7) == 0) dead = DT_W'($urandom_range(3));
      wait_neg(int'($urandom_range(60, 1)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule